// File: doc/BRIEF.md
# Instrument Bus Host Bridge

This bridge joins a host processor's pair of parallel ports to a shared 8-bit instrument bus. Every transfer takes two host accesses. First the host writes the bus register address to the address port. Then it writes a data byte, or asks for one, through the data port. The bridge keeps the latched address on the bus address lines. The top address bit picks the direction of the bidirectional data buffer. The bridge then runs a short strobe sequence: a settling wait, a single-cycle DATA VALID pulse, and a hold period in which a write keeps the bus data lines driven. In the cycle after a read's strobe, the bridge returns the byte it captured to the host.

An external controller can claim the bus by pulling a line low. A diagnostic disconnect input can also take the host off the bus. Either one at once releases the address, data, strobe and interrupt buffers, and the bridge drops any transfer in flight. The bidirectional data bus is modelled as separate in, out and output-enable signals. The analog delay networks become whole clock cycles set by parameters.

Top module: `ibus_bridge`

## Requirements
- R1: After a synchronous reset the following outputs are all 0: busy, bus_dv, bus_data_oe, host_rdata_vld, bus_addr and host_rdata.
- R2: When host_addr_wr is high on a clock edge, host_wdata appears on bus_addr in the next cycle. This holds only while the bridge is not busy and not isolated. host_addr_wr takes priority over a data-port access in the same cycle, and that data-port access is ignored.
- R3: bus_addr bit 7 sets the direction. If bit 7 is 0 (0x7F and below), a data-port write drives the byte onto bus_data_out and raises bus_data_oe. If bit 7 is 1 (0x80 and above), a data-port read leaves bus_data_oe at 0.
- R4: Number the cycles after the accepting edge from 1. bus_dv is high for exactly one cycle, cycle SETTLE_CYC+1, and stays low in every other cycle.
- R5: On a write, bus_data_oe rises in cycle 1 with no settling delay. It stays high for HOLD_CYC cycles after bus_dv falls, so it ends after cycle SETTLE_CYC+1+HOLD_CYC.
- R6: On a read, host_rdata takes the bus data sampled in the bus_dv cycle. host_rdata_vld is high for one cycle, cycle SETTLE_CYC+2.
- R7: If a read strobe finds bus_data_drv low, meaning no bus register drives the lines, the host receives 0xFF.
- R8: busy is high from cycle 1 through cycle SETTLE_CYC+1+HOLD_CYC. Address-port and data-port accesses made while busy are ignored.
- R9: While ext_ctl_n is 0 or diag_disc is 1, the following outputs are all 0 in that same cycle: bus_addr_oe, bus_data_oe, bus_dv and host_irq.
- R10: Host accesses made while isolated are ignored. A transfer in progress when isolation begins is dropped: busy is 0 in the next cycle and no host_rdata_vld follows.
- R11: When the bridge is not isolated, host_irq follows bus_irq_in in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wdata | input | 8 | Host byte for the address port or the data port |
| host_addr_wr | input | 1 | Host writes the address port |
| host_data_wr | input | 1 | Host writes the data port (bus write) |
| host_data_rd | input | 1 | Host reads the data port (bus read) |
| host_rdata | output | 8 | Byte captured from the bus |
| host_rdata_vld | output | 1 | One-cycle pulse: host_rdata is new |
| busy | output | 1 | Transfer sequence running |
| ext_ctl_n | input | 1 | External controller claims the bus when low |
| diag_disc | input | 1 | Diagnostic disconnect, active high |
| bus_addr | output | 8 | Bus address lines |
| bus_addr_oe | output | 1 | Address buffer enable |
| bus_data_out | output | 8 | Data driven toward the bus |
| bus_data_oe | output | 1 | Data buffer drive enable toward the bus |
| bus_data_in | input | 8 | Data lines as seen from the bus |
| bus_data_drv | input | 1 | Some bus register is driving the data lines |
| bus_dv | output | 1 | DATA VALID strobe |
| bus_irq_in | input | 1 | Interrupt request from the bus |
| host_irq | output | 1 | Gated interrupt toward the host |

## Verification
The checker tests these rules on every cycle:
- the isolation gating of all four buffers;
- the single-cycle width of DATA VALID;
- that the bridge never drives data while the address selects a read;
- that read data is reported only right after a strobe;
- that the write drive enable outlasts the strobe's falling edge.

The scenarios in the bench are needed for the cycle-exact position of the strobe after the settle count, and for the full length of busy. They also cover the values that reach the host, including the pulled-up 0xFF, and the rule that accesses made while busy or isolated leave the address unchanged. Finally, they show that a transfer cut short by isolation never produces read data.

// File: rtl/ibus_pkg.sv
package ibus_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETTLE,
        SEQ_STROBE,
        SEQ_HOLD
    } seq_state_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_t;

    typedef struct packed {
        xfer_dir_t         dir;
        logic [BUS_W-1:0]  wbyte;
    } xfer_req_t;

    function automatic xfer_dir_t dir_from_msb(input logic msb);
        return msb ? DIR_READ : DIR_WRITE;
    endfunction

    function automatic logic [BUS_W-1:0] undriven_byte();
        return '1;
    endfunction

endpackage

// File: rtl/ibus_addr_port.sv
module ibus_addr_port
    import ibus_pkg::*;
#(
    parameter int DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] addr,
    output xfer_dir_t         dir
);
    localparam int MSB = DATA_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= din;
        end
    end

    assign dir = dir_from_msb(addr[MSB]);
endmodule

// File: rtl/ibus_strobe_seq.sv
module ibus_strobe_seq
    import ibus_pkg::*;
#(
    parameter int SETTLE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic strobe,
    output logic active
);
    localparam int MAXC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] SETTLE_LOAD = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LOAD   = CW'(HOLD_CYC - 1);

    seq_state_t        state;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_SETTLE;
                        cnt   <= SETTLE_LOAD;
                    end
                end
                SEQ_SETTLE: begin
                    if (cnt == '0) state <= SEQ_STROBE;
                    else           cnt   <= cnt - 1'b1;
                end
                SEQ_STROBE: begin
                    state <= SEQ_HOLD;
                    cnt   <= HOLD_LOAD;
                end
                SEQ_HOLD: begin
                    if (cnt == '0) state <= SEQ_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign strobe = (state == SEQ_STROBE);
    assign active = (state != SEQ_IDLE);
endmodule

// File: rtl/ibus_isolate.sv
module ibus_isolate #(
    parameter int IRQ_W = 1
) (
    input  logic             ext_ctl_n,
    input  logic             diag_disc,
    input  logic             addr_en_in,
    input  logic             data_en_in,
    input  logic             dv_in,
    input  logic [IRQ_W-1:0] irq_in,
    output logic             isolated,
    output logic             addr_en,
    output logic             data_en,
    output logic             dv,
    output logic [IRQ_W-1:0] irq_out
);
    assign isolated = !ext_ctl_n || diag_disc;
    assign addr_en  = addr_en_in && !isolated;
    assign data_en  = data_en_in && !isolated;
    assign dv       = dv_in && !isolated;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
        assign irq_out[i] = irq_in[i] && !isolated;
    end
endmodule

// File: rtl/ibus_bridge.sv
module ibus_bridge
    import ibus_pkg::*;
#(
    parameter int DATA_W     = BUS_W,
    parameter int SETTLE_CYC = 2,
    parameter int HOLD_CYC   = 1,
    parameter int IRQ_W      = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_addr_wr,
    input  logic              host_data_wr,
    input  logic              host_data_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_vld,
    output logic              busy,
    input  logic              ext_ctl_n,
    input  logic              diag_disc,
    output logic [DATA_W-1:0] bus_addr,
    output logic              bus_addr_oe,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    input  logic              bus_data_drv,
    output logic              bus_dv,
    input  logic [IRQ_W-1:0]  bus_irq_in,
    output logic [IRQ_W-1:0]  host_irq
);
    logic      isolated;
    logic      seq_active;
    logic      seq_strobe;
    logic      accept_addr;
    logic      accept_data;
    xfer_dir_t addr_dir;
    xfer_req_t cur;

    assign accept_addr = host_addr_wr && !seq_active && !isolated;
    assign accept_data = (host_data_wr || host_data_rd) && !host_addr_wr
                         && !seq_active && !isolated;

    ibus_addr_port #(.DATA_W(DATA_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (accept_addr),
        .din  (host_wdata),
        .addr (bus_addr),
        .dir  (addr_dir)
    );

    ibus_strobe_seq #(.SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept_data),
        .abort  (isolated),
        .strobe (seq_strobe),
        .active (seq_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (accept_data) begin
            cur.dir   <= addr_dir;
            cur.wbyte <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata     <= '0;
            host_rdata_vld <= 1'b0;
        end else begin
            host_rdata_vld <= 1'b0;
            if (seq_strobe && cur.dir == DIR_READ && !isolated) begin
                host_rdata     <= bus_data_drv ? bus_data_in : undriven_byte();
                host_rdata_vld <= 1'b1;
            end
        end
    end

    ibus_isolate #(.IRQ_W(IRQ_W)) u_iso (
        .ext_ctl_n  (ext_ctl_n),
        .diag_disc  (diag_disc),
        .addr_en_in (1'b1),
        .data_en_in (seq_active && cur.dir == DIR_WRITE),
        .dv_in      (seq_strobe),
        .irq_in     (bus_irq_in),
        .isolated   (isolated),
        .addr_en    (bus_addr_oe),
        .data_en    (bus_data_oe),
        .dv         (bus_dv),
        .irq_out    (host_irq)
    );

    assign bus_data_out = cur.wbyte;
    assign busy         = seq_active;
endmodule

// File: rtl/ibus_bridge_chk.sv
module ibus_bridge_chk #(
    parameter int DATA_W = 8,
    parameter int IRQ_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_ctl_n,
    input logic              diag_disc,
    input logic              busy,
    input logic              bus_dv,
    input logic              bus_addr_oe,
    input logic              bus_data_oe,
    input logic [DATA_W-1:0] bus_addr,
    input logic              host_rdata_vld,
    input logic [IRQ_W-1:0]  host_irq
);
    logic iso;
    assign iso = !ext_ctl_n || diag_disc;

    assert_isolation_R9: assert property (@(posedge clk) disable iff (rst)
        iso |-> (!bus_addr_oe && !bus_data_oe && !bus_dv && host_irq == '0));

    assert_dv_single_R4: assert property (@(posedge clk) disable iff (rst)
        bus_dv |=> !bus_dv);

    assert_dv_inside_busy_R8: assert property (@(posedge clk) disable iff (rst)
        bus_dv |-> busy);

    assert_no_drive_on_read_R3: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> !bus_addr[DATA_W-1]);

    assert_rdata_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        host_rdata_vld |-> $past(bus_dv));

    assert_drive_outlasts_dv_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_dv) && !iso && !bus_addr[DATA_W-1]) |-> bus_data_oe);
endmodule

bind ibus_bridge ibus_bridge_chk #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ext_ctl_n      (ext_ctl_n),
    .diag_disc      (diag_disc),
    .busy           (busy),
    .bus_dv         (bus_dv),
    .bus_addr_oe    (bus_addr_oe),
    .bus_data_oe    (bus_data_oe),
    .bus_addr       (bus_addr),
    .host_rdata_vld (host_rdata_vld),
    .host_irq       (host_irq)
);

// File: tb/ibus_bridge_test.sv
module ibus_bridge_test;
    localparam int S = 2;
    localparam int H = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_wdata = '0;
    logic       host_addr_wr = 1'b0, host_data_wr = 1'b0, host_data_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_rdata_vld, busy;
    logic       ext_ctl_n = 1'b1, diag_disc = 1'b0;
    logic [7:0] bus_addr, bus_data_out;
    logic       bus_addr_oe, bus_data_oe, bus_dv;
    logic [7:0] bus_data_in = '0;
    logic       bus_data_drv = 1'b0;
    logic [0:0] bus_irq_in = '0;
    logic [0:0] host_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] expq[$];

    always #4 clk = ~clk;

    ibus_bridge #(.SETTLE_CYC(S), .HOLD_CYC(H)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: read results compared against queued expectations (R6, R7, R10)
    always @(negedge clk) begin
        if (!rst && host_rdata_vld) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R10 actual=unexpected_rdata_vld expected=none");
            end else begin
                chk("R6/R7 rdata", host_rdata, expq.pop_front());
            end
        end
    end

    task automatic addr_write(input logic [7:0] a);
        @(negedge clk); host_addr_wr = 1'b1; host_wdata = a;
        @(negedge clk); host_addr_wr = 1'b0;
    endtask

    // One full transfer, checked cycle by cycle; optional address write attempted while busy
    task automatic xfer(input bit rd, input logic [7:0] d, input bit bump);
        @(negedge clk);
        host_wdata = d;
        if (rd) host_data_rd = 1'b1; else host_data_wr = 1'b1;
        @(negedge clk);
        host_data_rd = 1'b0; host_data_wr = 1'b0;
        for (int n = 1; n <= S + H + 2; n++) begin
            chk("R4 dv", bus_dv, (n == S + 1));
            chk("R8 busy", busy, (n <= S + H + 1));
            chk("R3/R5 data_oe", bus_data_oe, (!rd && n <= S + H + 1));
            chk("R6 rdata_vld", host_rdata_vld, (rd && n == S + 2));
            if (!rd && n <= S + H + 1) chk("R3 data_out", bus_data_out, d);
            host_addr_wr = (bump && n == 2);
            if (bump && n == 2) host_wdata = 8'hEE;
            @(negedge clk);
        end
        host_addr_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 dv", bus_dv, 0);
        chk("R1 data_oe", bus_data_oe, 0);
        chk("R1 rdata_vld", host_rdata_vld, 0);
        chk("R1 bus_addr", bus_addr, 0);
        chk("R1 rdata", host_rdata, 0);

        // R2 address latch; R3/R4/R5 write
        addr_write(8'h12);
        chk("R2 bus_addr", bus_addr, 8'h12);
        chk("R2 addr_oe", bus_addr_oe, 1);
        xfer(0, 8'h5A, 1);
        chk("R8 addr ignored while busy", bus_addr, 8'h12);
        addr_write(8'h7F);
        xfer(0, 8'hC3, 0);

        // R6 driven reads
        addr_write(8'h85);
        bus_data_drv = 1'b1; bus_data_in = 8'h3C; expq.push_back(8'h3C);
        xfer(1, 8'h00, 0);
        bus_data_in = 8'hA5; expq.push_back(8'hA5);
        xfer(1, 8'h00, 0);
        // R7 undriven read returns all ones
        bus_data_drv = 1'b0; bus_data_in = 8'h00; expq.push_back(8'hFF);
        addr_write(8'h80);
        xfer(1, 8'h00, 0);

        // R2 priority: address write and data access in the same cycle
        @(negedge clk); host_addr_wr = 1'b1; host_data_wr = 1'b1; host_wdata = 8'h21;
        @(negedge clk); host_addr_wr = 1'b0; host_data_wr = 1'b0;
        chk("R2 addr priority", bus_addr, 8'h21);
        chk("R2 data ignored", busy, 0);

        // R11 interrupt pass-through
        bus_irq_in = 1'b1; #1;
        chk("R11 irq pass", host_irq, 1);

        // R9 isolation by external controller, R10 access ignored
        @(negedge clk); ext_ctl_n = 1'b0; #1;
        chk("R9 addr_oe", bus_addr_oe, 0);
        chk("R9 irq", host_irq, 0);
        addr_write(8'h01);
        @(negedge clk); host_data_wr = 1'b1;
        @(negedge clk); host_data_wr = 1'b0;
        chk("R10 no start", busy, 0);
        ext_ctl_n = 1'b1; #1;
        chk("R10 addr kept", bus_addr, 8'h21);
        chk("R11 irq back", host_irq, 1);
        @(negedge clk); diag_disc = 1'b1; #1;
        chk("R9 diag addr_oe", bus_addr_oe, 0);
        chk("R9 diag irq", host_irq, 0);
        @(negedge clk); diag_disc = 1'b0;

        // R10 abort of a write in progress
        @(negedge clk); host_wdata = 8'h66; host_data_wr = 1'b1;
        @(negedge clk); host_data_wr = 1'b0;
        chk("R5 immediate drive", bus_data_oe, 1);
        diag_disc = 1'b1; #1;
        chk("R9 drive cut", bus_data_oe, 0);
        @(negedge clk);
        chk("R10 abort busy", busy, 0);
        diag_disc = 1'b0;

        // R10 abort of a read: no rdata_vld may follow
        addr_write(8'h90);
        @(negedge clk); host_data_rd = 1'b1;
        @(negedge clk); host_data_rd = 1'b0;
        @(negedge clk); ext_ctl_n = 1'b0;
        @(negedge clk);
        chk("R10 read abort busy", busy, 0);
        ext_ctl_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 queue drained", expq.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule